// File: doc/BRIEF.md
# Flow-control calendar inserter

This block fills in the flow-control part of outgoing link control words. The user logic drives a long XON/XOFF status vector with one bit per calendar position. Each time a control-word slot comes up, the user pulses a request. The block then takes the next group of 16 status bits, places them into the control word in reversed order, and raises a flag when that group is the first one of the calendar. The calendar pointer advances only on a request. After the last group it wraps back to the first.

The block also packs the user's multi-use bits into their field. The usable width of that field shrinks as the channel-extension setting grows. When transmit is disabled, the word is marked as an idle control word but still carries flow-control status. Scrambling, CRC, meta-framing, striping and data framing are handled elsewhere. Every bit this block does not own is driven as zero, so a neighbour can OR in its own fields.

Top module: `fc_calendar_inserter`

## Requirements
- R1: While reset is active and in the cycles after it, `cw_valid`, `cw_idle` and `cw_word` are all zero. The first word after reset carries group 0.
- R2: A request sampled at a rising edge produces `cw_valid`=1 on the outputs registered at that same edge. In any cycle without a request, `cw_valid`, `cw_idle` and `cw_word` are all zero.
- R3: In a word carrying group g, bit 55-i equals status bit 16*g+i, for i from 0 to 15. A 1 is XON and a 0 is XOFF.
- R4: Successive words carry groups 0, 1, 2 and so on in order. Cycles without a request do not advance the group.
- R5: Bit 56 is 1 exactly on words carrying group 0. After group 15 (entries 240..255) the next word carries group 0 again.
- R6: The status bits are taken from `fc_status` at the edge where the request is sampled. A change made before that edge appears in the word.
- R7: With `tx_en` low at the request, `cw_idle` is 1, the flow-control bits and flag are still filled in, and the group still advances. With `tx_en` high, `cw_idle` is 0.
- R8: For channel extension e (0..3), bits [24+7-e:24] carry `mu_bits[7-e:0]` and bits [31:32-e] are zero.
- R9: Bits [63:57], [39:32] and [23:0] of `cw_word` are always zero.
- R10: Asserting reset in the middle of the calendar makes the next word carry group 0 with bit 56 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fc_status | input | 256 | Calendar status, one bit per entry, 1 = XON |
| cw_req | input | 1 | Control-word slot request |
| tx_en | input | 1 | Transmit enable; low marks the word idle |
| mu_bits | input | 8 | Multi-use bits |
| chan_ext | input | 2 | Channel-extension setting, reduces multi-use width |
| cw_word | output | 64 | Owned control-word fields, other bits zero |
| cw_valid | output | 1 | Word valid, one cycle per request |
| cw_idle | output | 1 | Word is an idle control word |

## Verification
A corrupted calendar pointer shows up on the next requested word. That word carries the wrong slice of the status vector, or bit 56 appears on the wrong word. A pointer that skips or stalls shifts every later group, so a sweep of all sixteen groups under several distinct status patterns exposes it within one calendar turn. A wrong reversal or mask shows at once in the bit positions of the flow-control or multi-use field. Reset in the middle of the calendar and idle gaps between requests check that only requests move the pointer.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  localparam int unsigned CW_W      = 64;
  localparam int unsigned CAL_GRP   = 16;
  localparam int unsigned FLAG_POS  = 56;
  localparam int unsigned FC_HI     = 55;
  localparam int unsigned FC_LO     = FC_HI - CAL_GRP + 1;
  localparam int unsigned MU_LO     = 24;
  localparam int unsigned MU_FULL_W = 8;
  localparam int unsigned EXT_W     = 2;

  typedef logic [CW_W-1:0]    cw_t;
  typedef logic [CAL_GRP-1:0] fc_grp_t;
endpackage

// File: rtl/fcc_rst_sync.sv
module fcc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/fcc_cal_ptr.sv
module fcc_cal_ptr #(
  parameter int unsigned NGRP  = 16,
  parameter int unsigned PTR_W = (NGRP > 1) ? $clog2(NGRP) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [PTR_W-1:0] ptr,
  output logic             at_start
);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NGRP - 1);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;

  always_comb begin
    ptr_en = adv;
    if (ptr_q == LAST) ptr_d = '0;
    else               ptr_d = ptr_q + PTR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr      = ptr_q;
  assign at_start = (ptr_q == '0);

  // R4
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q != LAST) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));

  // R4
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr_q));

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr_q == LAST) |=> (ptr_q == '0));
endmodule

// File: rtl/fcc_group_pick.sv
module fcc_group_pick
  import fcc_pkg::*;
#(
  parameter int unsigned ENTRIES = 256,
  parameter int unsigned PTR_W   = 4
) (
  input  logic [ENTRIES-1:0] status,
  input  logic [PTR_W-1:0]   grp_idx,
  output fc_grp_t            fc_field
);
  fc_grp_t slice;

  always_comb begin
    slice = status[int'(grp_idx) * CAL_GRP +: CAL_GRP];
  end

  // entry i of the group lands on the mirrored bit position
  for (genvar i = 0; i < CAL_GRP; i++) begin : g_rev
    assign fc_field[CAL_GRP-1-i] = slice[i];
  end
endmodule

// File: rtl/fcc_mu_pack.sv
module fcc_mu_pack
  import fcc_pkg::*;
(
  input  logic [MU_FULL_W-1:0] mu_in,
  input  logic [EXT_W-1:0]     ext,
  output logic [MU_FULL_W-1:0] mu_field
);
  int unsigned keep_w;

  always_comb begin
    keep_w = MU_FULL_W - int'(ext);
  end

  for (genvar b = 0; b < MU_FULL_W; b++) begin : g_mask
    assign mu_field[b] = (b < keep_w) ? mu_in[b] : 1'b0;
  end
endmodule

// File: rtl/fc_calendar_inserter.sv
module fc_calendar_inserter
  import fcc_pkg::*;
#(
  parameter int unsigned ENTRIES = 256
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ENTRIES-1:0]   fc_status,
  input  logic                 cw_req,
  input  logic                 tx_en,
  input  logic [MU_FULL_W-1:0] mu_bits,
  input  logic [EXT_W-1:0]     chan_ext,
  output logic [CW_W-1:0]      cw_word,
  output logic                 cw_valid,
  output logic                 cw_idle
);
  localparam int unsigned NGRP  = ENTRIES / CAL_GRP;
  localparam int unsigned PTR_W = (NGRP > 1) ? $clog2(NGRP) : 1;

  logic             rst_sn;
  logic [PTR_W-1:0] grp_ptr;
  logic             grp_start;
  fc_grp_t          fc_field;
  logic [MU_FULL_W-1:0] mu_field;

  cw_t  word_d, word_q;
  logic valid_d, valid_q;
  logic idle_d, idle_q;

  fcc_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_sn)
  );

  fcc_cal_ptr #(.NGRP(NGRP), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_sn), .adv(cw_req), .ptr(grp_ptr), .at_start(grp_start)
  );

  fcc_group_pick #(.ENTRIES(ENTRIES), .PTR_W(PTR_W)) u_pick (
    .status(fc_status), .grp_idx(grp_ptr), .fc_field(fc_field)
  );

  fcc_mu_pack u_mu (
    .mu_in(mu_bits), .ext(chan_ext), .mu_field(mu_field)
  );

  always_comb begin
    word_d  = '0;
    valid_d = cw_req;
    idle_d  = cw_req & ~tx_en;
    if (cw_req) begin
      word_d[FLAG_POS]                  = grp_start;
      word_d[FC_HI:FC_LO]               = fc_field;
      word_d[MU_LO+MU_FULL_W-1:MU_LO]   = mu_field;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      word_q  <= '0;
      valid_q <= 1'b0;
      idle_q  <= 1'b0;
    end else begin
      word_q  <= word_d;
      valid_q <= valid_d;
      idle_q  <= idle_d;
    end
  end

  assign cw_word  = word_q;
  assign cw_valid = valid_q;
  assign cw_idle  = idle_q;

  // R2
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cw_req |=> cw_valid);

  // R2
  quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !cw_req |=> (!cw_valid && !cw_idle && cw_word == '0));

  // R5
  start_flag_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cw_req |=> (cw_word[FLAG_POS] == $past(grp_start)));

  // R9
  unowned_zero_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cw_valid |-> (cw_word[63:57] == '0 && cw_word[39:32] == '0 && cw_word[23:0] == '0));

  // R7
  idle_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    cw_idle |-> cw_valid);
endmodule

// File: tb/fc_calendar_inserter_tb_top.sv
`timescale 1ns/1ps
module fc_calendar_inserter_tb_top;
  localparam int ENT = 256;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [ENT-1:0] fc_status;
  logic           cw_req;
  logic           tx_en;
  logic [7:0]     mu_bits;
  logic [1:0]     chan_ext;
  logic [63:0]    cw_word;
  logic           cw_valid;
  logic           cw_idle;

  int checks = 0;
  int fails  = 0;
  int grp    = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  fc_calendar_inserter #(.ENTRIES(ENT)) dut_i (
    .clk(clk), .rst_n(rst_n), .fc_status(fc_status), .cw_req(cw_req),
    .tx_en(tx_en), .mu_bits(mu_bits), .chan_ext(chan_ext),
    .cw_word(cw_word), .cw_valid(cw_valid), .cw_idle(cw_idle)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_fc(input logic [ENT-1:0] st, input int g);
    logic [15:0] f;
    for (int i = 0; i < 16; i++) f[15-i] = st[16*g+i];
    return f;
  endfunction

  function automatic logic [7:0] exp_mu(input logic [7:0] m, input int e);
    logic [7:0] r;
    for (int b = 0; b < 8; b++) r[b] = (b < 8 - e) ? m[b] : 1'b0;
    return r;
  endfunction

  function automatic logic pat(input int p, input int k);
    case (p)
      0: return (k % 3) == 0;
      1: return 1'(((k * 7 + 5) >> 2) & 1);
      2: return 1'b1;
      default: return k == 37;
    endcase
  endfunction

  // one request slot, checked on the next falling edge
  task automatic send();
    logic [63:0] expw;
    cw_req = 1'b1;
    @(negedge clk);
    cw_req = 1'b0;
    expw = '0;
    expw[56] = (grp == 0);
    expw[55:40] = exp_fc(fc_status, grp);
    expw[31:24] = exp_mu(mu_bits, int'(chan_ext));
    chk("R2 valid", {63'd0, cw_valid}, 64'd1);
    chk("R3 fc field", {48'd0, cw_word[55:40]}, {48'd0, expw[55:40]});
    chk("R5 start flag", {63'd0, cw_word[56]}, {63'd0, expw[56]});
    chk("R7 idle mark", {63'd0, cw_idle}, {63'd0, ~tx_en});
    chk("R8 mu field", {56'd0, cw_word[31:24]}, {56'd0, expw[31:24]});
    chk("R9 full word", cw_word, expw);
    grp = (grp + 1) % 16;
  endtask

  task automatic gap();
    @(negedge clk);
    chk("R2 quiet", {cw_word, 1'b0} >> 1, 64'd0);
    chk("R2 no valid", {62'd0, cw_valid, cw_idle}, 64'd0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {cw_word[62:0], cw_valid}, 64'd0);
    chk("R1 reset idle", {63'd0, cw_idle}, 64'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 after release", {62'd0, cw_valid, cw_idle}, 64'd0);
    grp = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fc_status = '0; cw_req = 1'b0; tx_en = 1'b1;
    mu_bits = 8'h00; chan_ext = 2'd0;
    @(negedge clk);
    do_reset();

    // R3 R4 R5: full calendar turns under four status patterns
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < ENT; k++) fc_status[k] = pat(p, k);
      mu_bits = 8'(8'h3C + p);
      for (int n = 0; n < 16; n++) send();
    end
    // R5 wrap: 17 words, the 17th again group 0
    for (int n = 0; n < 17; n++) send();

    // R4: gaps between requests do not move the group
    for (int n = 0; n < 6; n++) begin
      send();
      repeat (n % 3 + 1) gap();
    end

    // R6: status change just before a request is picked up
    for (int n = 0; n < 16; n++) begin
      for (int k = 0; k < 16; k++) fc_status[16*grp+k] = ((k + n) % 2) == 1;
      send();
    end

    // R7: transmit disabled still carries status and advances
    tx_en = 1'b0;
    for (int n = 0; n < 8; n++) send();
    tx_en = 1'b1;
    send();

    // R8: each channel-extension setting
    for (int e = 0; e < 4; e++) begin
      chan_ext = 2'(e);
      mu_bits = 8'hFF; send();
      mu_bits = 8'hA5; send();
      mu_bits = 8'h5A; send();
    end
    chan_ext = 2'd0;

    // R10: reset in the middle of the calendar
    while (grp != 5) send();
    do_reset();
    send();
    chk("R10 restart group 0", {63'd0, cw_word[56]}, 64'd1);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule